// File: doc/BRIEF.md
# Switched Output Fault Supervisor

This block is the per-channel digital supervisor of a switched power output. It decides cycle by cycle whether the pass switch may conduct. Its view of the analog side is a set of digital flags: the channel enable, a thermal-shutdown flag, a flag that says the output sits above the input, a reverse-current flag and a pulse that marks exit from current limiting. From these flags it drives the switch gate command, an active-low error line and a request that forces the channel's sense line to its fixed high level.

Before every turn-on the supervisor checks for an output shorted to the supply. A turn-on follows either a rising edge of the enable or the end of a thermal shutdown while the enable is high. A short found at that check latches the channel off. While the switch conducts, reverse current must persist for a debounce time before it latches the channel off. A blanking window stops ringing from tripping the detector; it starts at power-up, at each turn-on and at each current-limit exit. A latched fault clears only when its flag has gone inactive and the enable is low, and a new turn-on then needs a fresh rising edge of the enable. All inputs pass through two-flop synchronizers.

Top module: `outFaultSupervisor`

## Requirements
- R1: After reset the gate command is low, the error line is high and the sense-force request is low.
- R2: A rising edge of the enable with no fault flags active leads, after synchronization and one check cycle, to the gate command going high with the error line high.
- R3: If the output-above-input flag is active at the pre-turn-on check, the gate stays low, the error line goes low and the sense-force request goes high until the fault is cleared.
- R4: While thermal shutdown is active the gate is low and the error line is low. When the flag drops with the enable high, a pre-turn-on check runs and the switch turns on again.
- R5: Reverse current that stays active for DEB_CYC consecutive synchronized cycles during conduction, outside blanking, latches the switch off and drives the error line low, with sense-force low.
- R6: A reverse-current pulse shorter than DEB_CYC cycles does not trip, and the debounce count restarts from zero when the flag drops.
- R7: During the BLANK_CYC cycles after a turn-on, reverse current of any length is ignored and the gate stays high.
- R8: A current-limit-exit pulse restarts the blanking window, so reverse current that follows it is ignored and the gate stays high.
- R9: A latched fault stays latched while its fault flag is active, whatever the enable does. Once the flag is inactive and the enable is low, the error line returns high. A later enable rising edge turns the switch on again.
- R10: Enable low during conduction turns the gate off and leaves the error line high.
- R11: The output-above-input flag during conduction has no effect on the gate or the error line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enIn | input | 1 | Channel enable (asynchronous) |
| thermIn | input | 1 | Thermal-shutdown flag, high while hot |
| outHighIn | input | 1 | Output-above-input comparator flag |
| revCurIn | input | 1 | Reverse-current comparator flag |
| ilimExitIn | input | 1 | Pulse marking exit from current limiting |
| gateOn | output | 1 | Pass-switch gate command, high to conduct |
| errN | output | 1 | Error line, low on fault or thermal shutdown |
| senseForce | output | 1 | Request to pull the sense line to its fixed high level |

## Verification
The bench builds the supervisor with DEB_CYC = 4 and BLANK_CYC = 20. This replaces the defaults of 1000 and 3,200,000 cycles (5 µs and 16 ms at 200 MHz). With these values the debounce terminal count and the end of a blanking window fall within a few tens of cycles. Pulses one cycle short of the debounce count, reverse current that spans a restarted blanking window, and latch release in both orders of flag-drop and enable-low can therefore all be driven in one short run. A behavioural model runs beside the design and is compared on every clock.

// File: rtl/ofsPkg.sv
package ofsPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ON,
    ST_THERM,
    ST_LATCH_SHORT,
    ST_LATCH_REV
  } ofsState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic startBlank;
    logic conducting;
  } ofsStrobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic en;
    logic enRise;
    logic therm;
    logic outHigh;
    logic revCur;
    logic revTrip;
  } ofsFlags_t;

endpackage

// File: rtl/ofsSync.sv
module ofsSync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= {stage[STAGES-2:0], din};
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/ofsDatapath.sv
module ofsDatapath
  import ofsPkg::*;
#(
  parameter int DEB_CYC   = 1000,
  parameter int BLANK_CYC = 3200000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enIn,
  input  logic       thermIn,
  input  logic       outHighIn,
  input  logic       revCurIn,
  input  logic       ilimExitIn,
  input  ofsStrobe_t strobe,
  output ofsFlags_t  flags
);

  localparam int DEB_W   = $clog2(DEB_CYC + 1);
  localparam int BLANK_W = $clog2(BLANK_CYC + 1);
  localparam logic [DEB_W-1:0]   DEB_MAX   = DEB_W'(DEB_CYC);
  localparam logic [BLANK_W-1:0] BLANK_MAX = BLANK_W'(BLANK_CYC);
  localparam int N_IN = 5;

  logic [N_IN-1:0] rawVec;
  logic [N_IN-1:0] syncVec;
  logic sEn, sTherm, sOutHigh, sRev, sIlim;
  logic enPrev, ilimPrev;
  logic ilimRise;
  logic [DEB_W-1:0]   revCnt;
  logic [BLANK_W-1:0] blankCnt;
  logic blanking;

  assign rawVec = {ilimExitIn, revCurIn, outHighIn, thermIn, enIn};

  ofsSync #(.WIDTH(N_IN), .STAGES(2)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (rawVec),
    .dout(syncVec)
  );

  assign {sIlim, sRev, sOutHigh, sTherm, sEn} = syncVec;

  // edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev   <= 1'b0;
      ilimPrev <= 1'b0;
    end else begin
      enPrev   <= sEn;
      ilimPrev <= sIlim;
    end
  end

  assign ilimRise = sIlim & ~ilimPrev;

  // blanking window: loaded at power-up, turn-on, current-limit exit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                blankCnt <= BLANK_MAX;
    else if (strobe.startBlank || ilimRise)   blankCnt <= BLANK_MAX;
    else if (blankCnt != '0)                  blankCnt <= blankCnt - 1'b1;
  end

  assign blanking = (blankCnt != '0);

  // reverse-current debounce, saturates at terminal count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          revCnt <= '0;
    else if (!strobe.conducting || blanking || !sRev)   revCnt <= '0;
    else if (revCnt != DEB_MAX)                         revCnt <= revCnt + 1'b1;
  end

  assign flags.en      = sEn;
  assign flags.enRise  = sEn & ~enPrev;
  assign flags.therm   = sTherm;
  assign flags.outHigh = sOutHigh;
  assign flags.revCur  = sRev;
  assign flags.revTrip = (revCnt == DEB_MAX);

endmodule

// File: rtl/ofsControl.sv
module ofsControl
  import ofsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ofsFlags_t  flags,
  output ofsStrobe_t strobe,
  output logic       gateOn,
  output logic       errN,
  output logic       senseForce
);

  ofsState_e state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (flags.therm)       nextState = ST_THERM;
        else if (flags.enRise) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (flags.therm)        nextState = ST_THERM;
        else if (!flags.en)     nextState = ST_IDLE;
        else if (flags.outHigh) nextState = ST_LATCH_SHORT;
        else                    nextState = ST_ON;
      end
      ST_ON: begin
        if (flags.therm)        nextState = ST_THERM;
        else if (!flags.en)     nextState = ST_IDLE;
        else if (flags.revTrip) nextState = ST_LATCH_REV;
      end
      ST_THERM: begin
        if (!flags.therm) nextState = flags.en ? ST_CHECK : ST_IDLE;
      end
      ST_LATCH_SHORT: begin
        if (!flags.en && !flags.outHigh) nextState = ST_IDLE;
      end
      ST_LATCH_REV: begin
        if (!flags.en && !flags.revCur) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign strobe.startBlank = (state == ST_CHECK) && (nextState == ST_ON);
  assign strobe.conducting = (state == ST_ON);

  assign gateOn     = (state == ST_ON);
  assign errN       = !((state == ST_THERM) || (state == ST_LATCH_SHORT) ||
                        (state == ST_LATCH_REV));
  assign senseForce = (state == ST_LATCH_SHORT);

  AST_GATE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    gateOn |-> (errN && !senseForce)); // R2
  AST_SENSE_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    senseForce |-> (!gateOn && !errN)); // R3
  AST_THERM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    flags.therm |=> !gateOn); // R4
  AST_REV_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (gateOn && flags.revTrip && flags.en && !flags.therm) |=> (!gateOn && !errN && !senseForce)); // R5
  AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (senseForce && flags.outHigh) |=> senseForce); // R9
  AST_ON_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (gateOn && !flags.revTrip && flags.en && !flags.therm) |=> gateOn); // R11

endmodule

// File: rtl/outFaultSupervisor.sv
module outFaultSupervisor
  import ofsPkg::*;
#(
  parameter int DEB_CYC   = 1000,
  parameter int BLANK_CYC = 3200000
) (
  input  logic clk,
  input  logic rstN,
  input  logic enIn,
  input  logic thermIn,
  input  logic outHighIn,
  input  logic revCurIn,
  input  logic ilimExitIn,
  output logic gateOn,
  output logic errN,
  output logic senseForce
);

  ofsStrobe_t strobe;
  ofsFlags_t  flags;

  ofsDatapath #(.DEB_CYC(DEB_CYC), .BLANK_CYC(BLANK_CYC)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .enIn      (enIn),
    .thermIn   (thermIn),
    .outHighIn (outHighIn),
    .revCurIn  (revCurIn),
    .ilimExitIn(ilimExitIn),
    .strobe    (strobe),
    .flags     (flags)
  );

  ofsControl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .flags     (flags),
    .strobe    (strobe),
    .gateOn    (gateOn),
    .errN      (errN),
    .senseForce(senseForce)
  );

endmodule

// File: tb/outFaultSupervisor_test.sv
`timescale 1ns/1ps
module outFaultSupervisor_test;

  localparam int DEB   = 4;
  localparam int BLANK = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enIn = 0, thermIn = 0, outHighIn = 0, revCurIn = 0, ilimExitIn = 0;
  logic gateOn, errN, senseForce;

  int nChecks = 0;
  int nFails  = 0;
  bit running = 0;
  bit finished = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  outFaultSupervisor #(.DEB_CYC(DEB), .BLANK_CYC(BLANK)) uut (
    .clk(clk), .rstN(rstN), .enIn(enIn), .thermIn(thermIn),
    .outHighIn(outHighIn), .revCurIn(revCurIn), .ilimExitIn(ilimExitIn),
    .gateOn(gateOn), .errN(errN), .senseForce(senseForce)
  );

  // ---------------- behavioural reference model ----------------
  // mode: 0 idle, 1 check, 2 on, 3 thermal wait, 4 short latched, 5 reverse latched
  int mode;
  int blankLeft, revRun;
  bit q1[5], q2[5];   // two-cycle delay of {en, therm, outHigh, rev, ilim}
  bit enOld, ilimOld;
  int nMode, nBlank, nRev;
  bit rEn, rTh, rOh, rRv, rIl, rise, ilRise, trip;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode = 0; blankLeft = BLANK; revRun = 0;
      foreach (q1[i]) begin q1[i] = 0; q2[i] = 0; end
      enOld = 0; ilimOld = 0;
    end else begin
      rEn = q2[0]; rTh = q2[1]; rOh = q2[2]; rRv = q2[3]; rIl = q2[4];
      rise = rEn && !enOld;
      ilRise = rIl && !ilimOld;
      trip = (revRun == DEB);
      nMode = mode;
      case (mode)
        0: if (rTh) nMode = 3; else if (rise) nMode = 1;
        1: if (rTh) nMode = 3; else if (!rEn) nMode = 0; else if (rOh) nMode = 4; else nMode = 2;
        2: if (rTh) nMode = 3; else if (!rEn) nMode = 0; else if (trip) nMode = 5;
        3: if (!rTh) nMode = rEn ? 1 : 0;
        4: if (!rEn && !rOh) nMode = 0;
        5: if (!rEn && !rRv) nMode = 0;
        default: nMode = 0;
      endcase
      if ((mode == 1 && nMode == 2) || ilRise) nBlank = BLANK;
      else nBlank = (blankLeft > 0) ? blankLeft - 1 : 0;
      if (mode == 2 && blankLeft == 0 && rRv) nRev = (revRun < DEB) ? revRun + 1 : DEB;
      else nRev = 0;
      enOld = rEn; ilimOld = rIl;
      q2 = q1;
      q1[0] = enIn; q1[1] = thermIn; q1[2] = outHighIn; q1[3] = revCurIn; q1[4] = ilimExitIn;
      mode = nMode; blankLeft = nBlank; revRun = nRev;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      bit eG, eE, eS;
      eG = (mode == 2);
      eE = !(mode == 3 || mode == 4 || mode == 5);
      eS = (mode == 4);
      nChecks++;
      if (gateOn !== eG || errN !== eE || senseForce !== eS) begin
        nFails++;
        $display("FAIL %s cycle compare: actual gate=%b err_n=%b sense=%b expected gate=%b err_n=%b sense=%b",
                 curReq, gateOn, errN, senseForce, eG, eE, eS);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    running = 1;
    // R1 reset state
    curReq = "R1";
    chk("R1", "gate", gateOn, 1'b0);
    chk("R1", "err_n", errN, 1'b1);
    chk("R1", "sense", senseForce, 1'b0);
    step(25); // let power-up blanking expire

    // R2 turn-on
    curReq = "R2";
    enIn = 1; step(6);
    chk("R2", "gate after enable", gateOn, 1'b1);
    chk("R2", "err_n after enable", errN, 1'b1);

    // R7 reverse current inside blanking
    curReq = "R7";
    revCurIn = 1; step(10); revCurIn = 0;
    chk("R7", "gate during blanked reverse", gateOn, 1'b1);
    step(20);

    // R6 short reverse pulses
    curReq = "R6";
    for (int k = 0; k < 4; k++) begin
      revCurIn = 1; step(DEB - 1); revCurIn = 0; step(2);
    end
    step(4);
    chk("R6", "gate after short pulses", gateOn, 1'b1);

    // R11 output-above-input during conduction
    curReq = "R11";
    outHighIn = 1; step(10);
    chk("R11", "gate with out-high", gateOn, 1'b1);
    chk("R11", "err_n with out-high", errN, 1'b1);
    outHighIn = 0; step(3);

    // R8 current-limit exit restarts blanking
    curReq = "R8";
    ilimExitIn = 1; step(1); ilimExitIn = 0; step(2);
    revCurIn = 1; step(12);
    chk("R8", "gate in restarted blanking", gateOn, 1'b1);
    revCurIn = 0; step(25);

    // R5 persistent reverse current latches
    curReq = "R5";
    revCurIn = 1; step(DEB + 6);
    chk("R5", "gate after reverse", gateOn, 1'b0);
    chk("R5", "err_n after reverse", errN, 1'b0);
    chk("R5", "sense after reverse", senseForce, 1'b0);

    // R9 release only with flag gone and enable low
    curReq = "R9";
    enIn = 0; step(6);
    chk("R9", "err_n enable low, flag active", errN, 1'b0);
    enIn = 1; step(6);
    chk("R9", "gate relatch re-enable", gateOn, 1'b0);
    revCurIn = 0; step(6);
    chk("R9", "err_n flag gone, enable high", errN, 1'b0);
    enIn = 0; step(5);
    chk("R9", "err_n released", errN, 1'b1);
    enIn = 1; step(6);
    chk("R9", "gate after re-enable", gateOn, 1'b1);

    // R10 enable low turns off
    curReq = "R10";
    enIn = 0; step(5);
    chk("R10", "gate enable low", gateOn, 1'b0);
    chk("R10", "err_n enable low", errN, 1'b1);

    // R3 pre-turn-on short detection
    curReq = "R3";
    outHighIn = 1; step(3);
    enIn = 1; step(6);
    chk("R3", "gate with short", gateOn, 1'b0);
    chk("R3", "err_n with short", errN, 1'b0);
    chk("R3", "sense with short", senseForce, 1'b1);
    curReq = "R9";
    enIn = 0; step(5);
    chk("R9", "sense held while short present", senseForce, 1'b1);
    outHighIn = 0; step(5);
    chk("R9", "sense released", senseForce, 1'b0);
    chk("R9", "err_n released after short", errN, 1'b1);
    enIn = 1; step(6);
    chk("R9", "gate after short cleared", gateOn, 1'b1);

    // R4 thermal shutdown and recovery
    curReq = "R4";
    step(25);
    thermIn = 1; step(5);
    chk("R4", "gate thermal", gateOn, 1'b0);
    chk("R4", "err_n thermal", errN, 1'b0);
    thermIn = 0; step(6);
    chk("R4", "gate after thermal exit", gateOn, 1'b1);
    chk("R4", "err_n after thermal exit", errN, 1'b1);
    // short present at thermal exit latches
    thermIn = 1; step(4); outHighIn = 1; step(3); thermIn = 0; step(6);
    chk("R4", "sense on short at thermal exit", senseForce, 1'b1);
    outHighIn = 0; enIn = 0; step(6);
    // thermal while idle
    thermIn = 1; step(5);
    chk("R4", "err_n thermal idle", errN, 1'b0);
    thermIn = 0; step(5);
    chk("R4", "err_n thermal exit idle", errN, 1'b1);
    chk("R4", "gate thermal exit idle", gateOn, 1'b0);

    step(3);
    running = 0;
    finish_run();
  end

endmodule